// File: doc/BRIEF.md
# Dual Mailbox Register With Lane Restriction

This block holds two single-entry message registers. They let a 36-bit wide port and two narrower 18-bit ports exchange short messages without going through any queue memory. The "down" mailbox carries a word from the wide port to the narrow read port. The "up" mailbox carries a word from the narrow write port into the upper half of the wide port. Each mailbox has its own write strobe, its own read strobe on the opposite port, and a full flag. An accepted write sets the flag and a read by the receiving side clears it. The stored value stays in place after a read and is replaced only by the next accepted write.

Each narrow port is set to either word (18-bit) or byte (9-bit) width. Those settings are captured while reset is held and stay fixed until the next reset. In byte mode only the low byte lane of that narrow port carries mailbox data. All output bits outside the active lanes are driven to zero, so results are deterministic. Bits keep their positions, and there is no byte reordering option for mailbox traffic. Every port runs on one shared clock.

Top module: `mbox_pair`

## Requirements
- R1: After reset both full flags read 0 and both data outputs `b_rdata` and `a_rdata` read all zeros.
- R2: A write strobe on an empty mailbox stores the data. The full flag and the data output show the new value after that same clock edge.
- R3: A read strobe from the receiving port while the mailbox is full clears the flag on that edge. The data output keeps its value.
- R4: A write strobe while the mailbox is full is ignored: the flag stays 1 and the stored value is unchanged. This also holds when a read clears the flag in the same cycle.
- R5: With the read port in word mode (`rd_size_byte`=0), `b_rdata[i]` equals the written `a_wdata[i]` for i in 0..17. `a_wdata[35:18]` has no effect.
- R6: With the read port in byte mode (`rd_size_byte`=1), `b_rdata[8:0]` equals `a_wdata[8:0]` and `b_rdata[17:9]` reads 0.
- R7: With the write port in word mode (`wr_size_byte`=0), `a_rdata[18+i]` equals the written `c_wdata[i]` for i in 0..17, and `a_rdata[17:0]` reads 0.
- R8: With the write port in byte mode (`wr_size_byte`=1), `a_rdata[26:18]` equals `c_wdata[8:0]`. `a_rdata[35:27]` and `a_rdata[17:0]` read 0, and `c_wdata[17:9]` has no effect.
- R9: The size inputs are sampled only while `rst_n` is low. Changing them after reset is released has no effect until the next reset.
- R10: Write strobes asserted during reset have no effect. A read strobe on an empty mailbox leaves its flag at 0.
- R11: The two mailboxes are independent: writes to both in the same cycle are both accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low reset; clears flags and data, samples size inputs |
| rd_size_byte | input | 1 | Narrow read port width: 1 byte, 0 word |
| wr_size_byte | input | 1 | Narrow write port width: 1 byte, 0 word |
| a_mb_wr | input | 1 | Wide port write strobe into the down mailbox |
| a_wdata | input | 36 | Wide port write data |
| a_mb_rd | input | 1 | Wide port read strobe for the up mailbox |
| a_rdata | output | 36 | Up mailbox contents placed on the upper lanes |
| a_mb_full | output | 1 | Up mailbox holds unread data |
| b_mb_rd | input | 1 | Narrow read port strobe for the down mailbox |
| b_rdata | output | 18 | Down mailbox contents |
| b_mb_full | output | 1 | Down mailbox holds unread data |
| c_mb_wr | input | 1 | Narrow write port strobe into the up mailbox |
| c_wdata | input | 18 | Narrow write port data |

## Verification
A stuck or wrong full flag shows on `a_mb_full` or `b_mb_full` one edge after the strobe that should have moved it. A data register that was overwritten by mistake shows on the data outputs immediately, because they are driven straight from storage. A lane gate that lets a disabled bit through shows as a nonzero upper bit on the first accepted write in byte mode. A size setting that follows its pin after reset shows as widened data on the first write after the pin changes.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic {
    LANE_WORD = 1'b0,
    LANE_BYTE = 1'b1
  } lane_size_e;

  typedef struct packed {
    lane_size_e rd_size;
    lane_size_e wr_size;
  } mbox_cfg_t;

  function automatic logic is_byte(input lane_size_e s);
    return s == LANE_BYTE;
  endfunction

endpackage

// File: rtl/mbox_cfg_latch.sv
module mbox_cfg_latch
  import mbox_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rd_byte_pin,
  input  logic      wr_byte_pin,
  output mbox_cfg_t cfg_q
);

  logic run_q;

  // Sizes track their pins only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.rd_size <= lane_size_e'(rd_byte_pin);
      cfg_q.wr_size <= lane_size_e'(wr_byte_pin);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(cfg_q)) else $error("size config moved after reset"); // R9

endmodule

// File: rtl/mbox_lane_gate.sv
module mbox_lane_gate #(
  parameter int W      = 18,
  parameter int BYTE_W = 9
) (
  input  logic [W-1:0] din,
  input  logic         byte_mode,
  output logic [W-1:0] dout
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < BYTE_W) begin : g_keep
      assign dout[i] = din[i];
    end else begin : g_cut
      assign dout[i] = din[i] & ~byte_mode;
    end
  end

endmodule

// File: rtl/mbox_slot.sv
module mbox_slot #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic [W-1:0] data_q,
  output logic         full_q
);

  logic wr_take;
  logic rd_take;

  assign wr_take = wr_req & ~full_q;
  assign rd_take = rd_req & full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (wr_take) begin
        data_q <= wr_data;
        full_q <= 1'b1;
      end else if (rd_take) begin
        full_q <= 1'b0;
      end
    end
  end

  AST_WR_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> (full_q && data_q == $past(wr_data))) else $error("write not taken"); // R2
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> !full_q) else $error("read did not clear flag"); // R3
  AST_DATA_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_take |=> $stable(data_q)) else $error("data moved without write"); // R4
  AST_FULL_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && wr_req && !rd_req) |=> full_q) else $error("full flag lost"); // R4
  AST_EMPTY_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_q && rd_req && !wr_req) |=> !full_q) else $error("empty read set flag"); // R10

endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
  import mbox_pkg::*;
#(
  parameter int WIDE_W   = 36,
  parameter int NARROW_W = 18,
  parameter int BYTE_W   = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_size_byte,
  input  logic                wr_size_byte,
  input  logic                a_mb_wr,
  input  logic [WIDE_W-1:0]   a_wdata,
  input  logic                a_mb_rd,
  output logic [WIDE_W-1:0]   a_rdata,
  output logic                a_mb_full,
  input  logic                b_mb_rd,
  output logic [NARROW_W-1:0] b_rdata,
  output logic                b_mb_full,
  input  logic                c_mb_wr,
  input  logic [NARROW_W-1:0] c_wdata
);

  localparam int PAD_W = WIDE_W - NARROW_W;

  mbox_cfg_t           cfg;
  logic                rd_is_byte;
  logic                wr_is_byte;
  logic [NARROW_W-1:0] down_in;
  logic [NARROW_W-1:0] up_in;
  logic [NARROW_W-1:0] up_q;
  logic                unused_a_hi;

  assign unused_a_hi = ^a_wdata[WIDE_W-1:NARROW_W];

  mbox_cfg_latch u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_byte_pin (rd_size_byte),
    .wr_byte_pin (wr_size_byte),
    .cfg_q       (cfg)
  );

  assign rd_is_byte = is_byte(cfg.rd_size);
  assign wr_is_byte = is_byte(cfg.wr_size);

  mbox_lane_gate #(.W(NARROW_W), .BYTE_W(BYTE_W)) u_gate_down (
    .din       (a_wdata[NARROW_W-1:0]),
    .byte_mode (rd_is_byte),
    .dout      (down_in)
  );

  mbox_lane_gate #(.W(NARROW_W), .BYTE_W(BYTE_W)) u_gate_up (
    .din       (c_wdata),
    .byte_mode (wr_is_byte),
    .dout      (up_in)
  );

  mbox_slot #(.W(NARROW_W)) u_down (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (a_mb_wr),
    .wr_data (down_in),
    .rd_req  (b_mb_rd),
    .data_q  (b_rdata),
    .full_q  (b_mb_full)
  );

  mbox_slot #(.W(NARROW_W)) u_up (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (c_mb_wr),
    .wr_data (up_in),
    .rd_req  (a_mb_rd),
    .data_q  (up_q),
    .full_q  (a_mb_full)
  );

  assign a_rdata = {up_q, {PAD_W{1'b0}}};

  AST_DOWN_BYTE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_is_byte |-> (b_rdata[NARROW_W-1:BYTE_W] == '0)) else $error("down lane leak"); // R6
  AST_UP_BYTE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_is_byte |-> (a_rdata[WIDE_W-1:PAD_W+BYTE_W] == '0)) else $error("up lane leak"); // R8

endmodule

// File: tb/test_mbox_pair.sv
module test_mbox_pair;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  typedef struct packed {
    logic        a_wr;
    logic [35:0] a_d;
    logic        b_rd;
    logic        c_wr;
    logic [17:0] c_d;
    logic        a_rd;
    logic [17:0] exp_b;
    logic        exp_bf;
    logic [35:0] exp_a;
    logic        exp_af;
  } vec_t;

  // Word mode on both narrow ports.
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 36'h987654321, 1'b0, 1'b0, 18'h00000, 1'b0, 18'h14321, 1'b1, 36'h000000000, 1'b0}, // R2 R5
    '{1'b1, 36'h00003FFFF, 1'b0, 1'b1, 18'h2ABCD, 1'b0, 18'h14321, 1'b1, 36'hAAF340000, 1'b1}, // R4 R7
    '{1'b0, 36'h000000000, 1'b1, 1'b0, 18'h00000, 1'b1, 18'h14321, 1'b0, 36'hAAF340000, 1'b0}, // R3
    '{1'b0, 36'h000000000, 1'b1, 1'b0, 18'h00000, 1'b0, 18'h14321, 1'b0, 36'hAAF340000, 1'b0}, // R10
    '{1'b1, 36'hFFFFC0000, 1'b0, 1'b0, 18'h00000, 1'b0, 18'h00000, 1'b1, 36'hAAF340000, 1'b0}, // R5
    '{1'b1, 36'h00003FFFF, 1'b1, 1'b0, 18'h00000, 1'b0, 18'h00000, 1'b0, 36'hAAF340000, 1'b0}, // R4
    '{1'b1, 36'h00003FFFF, 1'b0, 1'b1, 18'h00001, 1'b1, 18'h3FFFF, 1'b1, 36'h000040000, 1'b1}, // R11
    '{1'b0, 36'h000000000, 1'b0, 1'b0, 18'h00000, 1'b0, 18'h3FFFF, 1'b1, 36'h000040000, 1'b1}  // R3
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_size_byte, wr_size_byte;
  logic        a_mb_wr, a_mb_rd, b_mb_rd, c_mb_wr;
  logic [35:0] a_wdata, a_rdata;
  logic [17:0] b_rdata, c_wdata;
  logic        a_mb_full, b_mb_full;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_pair i_mbox_pair (
    .clk(clk), .rst_n(rst_n),
    .rd_size_byte(rd_size_byte), .wr_size_byte(wr_size_byte),
    .a_mb_wr(a_mb_wr), .a_wdata(a_wdata), .a_mb_rd(a_mb_rd),
    .a_rdata(a_rdata), .a_mb_full(a_mb_full),
    .b_mb_rd(b_mb_rd), .b_rdata(b_rdata), .b_mb_full(b_mb_full),
    .c_mb_wr(c_mb_wr), .c_wdata(c_wdata)
  );

  function automatic logic [17:0] model_b(input logic [35:0] d, input bit byte_m);
    logic [17:0] r;
    r = d[17:0];
    if (byte_m) r[17:9] = '0;
    return r;
  endfunction

  function automatic logic [35:0] model_a(input logic [17:0] d, input bit byte_m);
    logic [35:0] r;
    r = '0;
    for (int i = 0; i < 18; i++)
      if (!byte_m || i < 9) r[18+i] = d[i];
    return r;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [35:0] act, input logic [35:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic aw, input logic [35:0] ad, input logic br,
                     input logic cw, input logic [17:0] cd, input logic ar);
    a_mb_wr = aw; a_wdata = ad; b_mb_rd = br;
    c_mb_wr = cw; c_wdata = cd; a_mb_rd = ar;
    @(posedge clk);
    @(negedge clk);
    a_mb_wr = 1'b0; b_mb_rd = 1'b0; c_mb_wr = 1'b0; a_mb_rd = 1'b0;
  endtask

  task automatic do_reset(input bit rb, input bit wb, input bit strobe);
    rst_n = 1'b0;
    rd_size_byte = rb; wr_size_byte = wb;
    a_mb_wr = strobe; c_mb_wr = strobe;
    a_wdata = '1; c_wdata = '1;
    a_mb_rd = 1'b0; b_mb_rd = 1'b0;
    repeat (3) @(negedge clk);
    a_mb_wr = 1'b0; c_mb_wr = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset(1'b0, 1'b0, 1'b0);
    chk("R1", "b_full",  {35'b0, b_mb_full}, 36'h0);
    chk("R1", "a_full",  {35'b0, a_mb_full}, 36'h0);
    chk("R1", "b_rdata", {18'b0, b_rdata},   36'h0);
    chk("R1", "a_rdata", a_rdata,            36'h0);

    for (int k = 0; k < NVEC; k++) begin
      cyc(VECS[k].a_wr, VECS[k].a_d, VECS[k].b_rd, VECS[k].c_wr, VECS[k].c_d, VECS[k].a_rd);
      chk("R2-table", $sformatf("row%0d b_rdata", k), {18'b0, b_rdata}, {18'b0, VECS[k].exp_b});
      chk("R3-table", $sformatf("row%0d b_full", k), {35'b0, b_mb_full}, {35'b0, VECS[k].exp_bf});
      chk("R7-table", $sformatf("row%0d a_rdata", k), a_rdata, VECS[k].exp_a);
      chk("R4-table", $sformatf("row%0d a_full", k), {35'b0, a_mb_full}, {35'b0, VECS[k].exp_af});
    end

    // R10: strobes held during reset, byte mode on both ports
    do_reset(1'b1, 1'b1, 1'b1);
    chk("R10", "b_full",  {35'b0, b_mb_full}, 36'h0);
    chk("R10", "a_full",  {35'b0, a_mb_full}, 36'h0);
    chk("R10", "b_rdata", {18'b0, b_rdata},   36'h0);
    chk("R10", "a_rdata", a_rdata,            36'h0);

    // R9: pins go back to word after release; byte mode must stay
    rd_size_byte = 1'b0; wr_size_byte = 1'b0;
    cyc(1'b1, 36'h123456FFF, 1'b0, 1'b1, 18'h3FFFF, 1'b0);
    chk("R6", "b_rdata byte", {18'b0, b_rdata}, {18'b0, model_b(36'h123456FFF, 1'b1)});
    chk("R8", "a_rdata byte", a_rdata, model_a(18'h3FFFF, 1'b1));
    chk("R9", "a_rdata frozen", a_rdata, 36'h007FC0000);
    chk("R9", "b_rdata frozen", {18'b0, b_rdata}, 36'h0000001FF);

    // R5 R7: new reset in word mode restores full lanes
    do_reset(1'b0, 1'b0, 1'b0);
    cyc(1'b1, 36'hFFFFFFFFF, 1'b0, 1'b1, 18'h2D2D2, 1'b0);
    chk("R5", "b_rdata word", {18'b0, b_rdata}, {18'b0, model_b(36'hFFFFFFFFF, 1'b0)});
    chk("R7", "a_rdata word", a_rdata, model_a(18'h2D2D2, 1'b0));
    chk("R11", "both full", {34'b0, a_mb_full, b_mb_full}, 36'h3);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule